// File: doc/BRIEF.md
# Pipelined Virtual-Channel Input Stage

This block is the per-input-port front end of a three-stage virtual-channel router. The three stages are route computation, output-VC allocation, and switch allocation fused with switch traversal. Flits arrive one per cycle, each tagged with its input VC, and land in that VC's FIFO. The FIFO feeds a single-slot elastic buffer that belongs to the same VC. A head flit computes its output port when it enters that slot. It then asks an external VC allocator for an output VC of that port. Once it holds the output VC, it competes in an external switch allocator. The switch winner is copied into an output pipeline register together with its output port and output VC.

Route results and allocated VCs are held in per-VC state: a port register, a VC register and a lock bit. Each result is written in one cycle and is used by the next stage in the following cycle. No path lets a head flit skip a stage. Body and tail flits reuse the state their head left behind. A tail flit that wins the switch drops the lock, and the next packet on that VC then allocates again.

The elastic slot is ready when it is empty or when its occupant leaves in the same cycle. The follower can therefore enter as the leader departs, so a packet streams out without gaps. VCs of the same port proceed independently.

Top module: `vc_input_stage`

## Requirements
- R1: While reset is asserted, and after it is released, `out_valid_o`, `va_req_o` and `sa_req_o` are low. All FIFO and elastic-slot contents present at reset are discarded and never appear at the output.
- R2: A flit is `{head, tail, dest[DEST_W-1:0], payload[DATA_W-1:0]}`, with head as the MSB. The output port of a packet is the low `PORT_W` bits of its head flit's dest field.
- R3: A head flit written at clock edge N, into an idle VC with allocators that grant at once and a credit present, is in the output register after edge N+3.
- R4: `va_req_o[v]` is raised in the cycle after a head flit enters VC v's elastic slot. It carries that head's port on `va_port_o[v*PORT_W +: PORT_W]` and holds steady until granted. The granted VC id from `va_gnt_vc_i` is kept as the packet's output VC.
- R5: The body and tail flits of a packet written on consecutive cycles leave on consecutive cycles behind the head, with no bubble.
- R6: `sa_req_o[v]` is raised only when VC v's slot holds a flit, VC v holds an output VC, and `cred_ok_i[port*NUM_VC + outvc]` is 1. While the credit is missing, the flit waits and is not lost.
- R7: When a tail flit wins switch allocation, its VC gives up the output VC. A following packet on the same VC allocates again and leaves exactly two cycles after that tail, leaving one idle cycle.
- R8: VCs are independent: one VC can route and allocate while another streams flits out. Under fixed-priority switch grants, two interleaved packets leave in six consecutive cycles.
- R9: Body and tail flits ignore their own dest field. They leave on the port and output VC held by their packet's head. Flit bits pass through unchanged and in order within each VC.
- R10: A switch grant to VC v in a cycle puts that VC's flit, port and output VC on `out_*_o` after the next edge. `out_valid_o` is high only then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Incoming flit valid |
| in_vc_i | input | VC_W (1) | Input VC of the incoming flit |
| in_flit_i | input | FLIT_W (22) | Incoming flit |
| va_req_o | output | NUM_VC (2) | Per-VC output-VC allocation request |
| va_port_o | output | NUM_VC*PORT_W (4) | Per-VC requested output port |
| va_gnt_i | input | NUM_VC (2) | Per-VC allocation grant |
| va_gnt_vc_i | input | NUM_VC*VC_W (2) | Per-VC granted output VC id |
| cred_ok_i | input | NUM_PORT*NUM_VC (8) | Credit available per output VC, index port*NUM_VC+vc |
| sa_req_o | output | NUM_VC (2) | Per-VC switch request |
| sa_gnt_i | input | NUM_VC (2) | Per-VC switch grant, at most one |
| out_valid_o | output | 1 | Output register holds a flit |
| out_flit_o | output | FLIT_W (22) | Flit leaving through the switch |
| out_port_o | output | PORT_W (2) | Its output port |
| out_vc_o | output | VC_W (1) | Its output VC |

## Verification
The assertions assume the following about the inputs. A switch grant goes to at most one VC, and only to a VC that is requesting. Upstream never writes into a full VC FIFO. Packets on a VC arrive whole and in head-body-tail order. The bench's allocator models meet all three: a fixed-priority switch arbiter that grants only requesters, an allocation responder that grants only requesters, and short packets that fit the FIFO depth. Stalls are made only by withholding the allocation grant or the credit, never by breaking these assumptions.

// File: rtl/vcis_pkg.sv
package vcis_pkg;
  typedef struct packed {
    logic head;
    logic tail;
  } flit_kind_t;
endpackage

// File: rtl/vcis_fifo.sv
module vcis_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic         valid_o,
  output logic [W-1:0] data_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign valid_o = (cnt != '0);
  assign data_o  = mem[rd_ptr];
  assign do_pop  = pop_i && valid_o;
  assign do_push = push_i && (cnt != CW'(DEPTH));

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= nxt(wr_ptr);
      if (do_pop)  rd_ptr <= nxt(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_ptr] <= data_i;
  end
endmodule

// File: rtl/vcis_vc_ctrl.sv
module vcis_vc_ctrl
  import vcis_pkg::*;
#(
  parameter int NUM_VC   = 2,
  parameter int NUM_PORT = 4,
  parameter int DEST_W   = 4,
  parameter int DATA_W   = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       fifo_valid_i,
  input  logic [2+DEST_W+DATA_W-1:0] fifo_flit_i,
  output logic                       fifo_pop_o,
  output logic                       va_req_o,
  output logic [$clog2(NUM_PORT)-1:0] va_port_o,
  input  logic                       va_gnt_i,
  input  logic [$clog2(NUM_VC)-1:0]  va_gnt_vc_i,
  input  logic [NUM_PORT*NUM_VC-1:0] cred_ok_i,
  output logic                       sa_req_o,
  input  logic                       sa_gnt_i,
  output logic [2+DEST_W+DATA_W-1:0] eb_flit_o,
  output logic [$clog2(NUM_PORT)-1:0] out_port_o,
  output logic [$clog2(NUM_VC)-1:0]  out_vc_o
);
  localparam int FLIT_W = 2 + DEST_W + DATA_W;
  localparam int PORT_W = $clog2(NUM_PORT);
  localparam int VC_W   = $clog2(NUM_VC);

  logic              eb_vld;
  logic [FLIT_W-1:0] eb_q;
  logic [PORT_W-1:0] port_q;
  logic [VC_W-1:0]   ovc_q;
  logic              lock_q;
  flit_kind_t        in_kind, eb_kind;
  logic              eb_pop, eb_ready, load;

  assign in_kind = flit_kind_t'(fifo_flit_i[FLIT_W-1 -: 2]);
  assign eb_kind = flit_kind_t'(eb_q[FLIT_W-1 -: 2]);

  assign va_req_o = eb_vld && eb_kind.head && !lock_q;
  assign sa_req_o = eb_vld && lock_q && cred_ok_i[{port_q, ovc_q}];
  assign eb_pop   = sa_req_o && sa_gnt_i;
  // ready seen in the same cycle the occupant departs
  assign eb_ready = !eb_vld || eb_pop;
  assign load     = fifo_valid_i && eb_ready;

  assign fifo_pop_o = load;
  assign va_port_o  = port_q;
  assign eb_flit_o  = eb_q;
  assign out_port_o = port_q;
  assign out_vc_o   = ovc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eb_vld <= 1'b0;
      eb_q   <= '0;
      port_q <= '0;
    end else if (load) begin
      eb_vld <= 1'b1;
      eb_q   <= fifo_flit_i;
      if (in_kind.head) port_q <= fifo_flit_i[DATA_W +: PORT_W];
    end else if (eb_pop) begin
      eb_vld <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= 1'b0;
      ovc_q  <= '0;
    end else if (va_req_o && va_gnt_i) begin
      lock_q <= 1'b1;
      ovc_q  <= va_gnt_vc_i;
    end else if (eb_pop && eb_kind.tail) begin
      lock_q <= 1'b0;
    end
  end
endmodule

// File: rtl/vcis_out_reg.sv
module vcis_out_reg #(
  parameter int NUM_VC = 2,
  parameter int FLIT_W = 22,
  parameter int PORT_W = 2,
  parameter int VC_W   = 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_VC-1:0]        sel_i,
  input  logic [NUM_VC*FLIT_W-1:0] flits_i,
  input  logic [NUM_VC*PORT_W-1:0] ports_i,
  input  logic [NUM_VC*VC_W-1:0]   vcs_i,
  output logic                     valid_o,
  output logic [FLIT_W-1:0]        flit_o,
  output logic [PORT_W-1:0]        port_o,
  output logic [VC_W-1:0]          vc_o
);
  logic [FLIT_W-1:0] flit_d;
  logic [PORT_W-1:0] port_d;
  logic [VC_W-1:0]   vc_d;

  always_comb begin
    flit_d = '0;
    port_d = '0;
    vc_d   = '0;
    for (int v = 0; v < NUM_VC; v++) begin
      flit_d |= flits_i[v*FLIT_W +: FLIT_W] & {FLIT_W{sel_i[v]}};
      port_d |= ports_i[v*PORT_W +: PORT_W] & {PORT_W{sel_i[v]}};
      vc_d   |= vcs_i[v*VC_W +: VC_W]       & {VC_W{sel_i[v]}};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      flit_o  <= '0;
      port_o  <= '0;
      vc_o    <= '0;
    end else begin
      valid_o <= |sel_i;
      if (|sel_i) begin
        flit_o <= flit_d;
        port_o <= port_d;
        vc_o   <= vc_d;
      end
    end
  end
endmodule

// File: rtl/vc_input_stage.sv
module vc_input_stage #(
  parameter int NUM_VC     = 2,
  parameter int NUM_PORT   = 4,
  parameter int DEST_W     = 4,
  parameter int DATA_W     = 16,
  parameter int FIFO_DEPTH = 4,
  localparam int FLIT_W    = 2 + DEST_W + DATA_W,
  localparam int PORT_W    = $clog2(NUM_PORT),
  localparam int VC_W      = $clog2(NUM_VC)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       in_valid_i,
  input  logic [VC_W-1:0]            in_vc_i,
  input  logic [FLIT_W-1:0]          in_flit_i,
  output logic [NUM_VC-1:0]          va_req_o,
  output logic [NUM_VC*PORT_W-1:0]   va_port_o,
  input  logic [NUM_VC-1:0]          va_gnt_i,
  input  logic [NUM_VC*VC_W-1:0]     va_gnt_vc_i,
  input  logic [NUM_PORT*NUM_VC-1:0] cred_ok_i,
  output logic [NUM_VC-1:0]          sa_req_o,
  input  logic [NUM_VC-1:0]          sa_gnt_i,
  output logic                       out_valid_o,
  output logic [FLIT_W-1:0]          out_flit_o,
  output logic [PORT_W-1:0]          out_port_o,
  output logic [VC_W-1:0]            out_vc_o
);
  logic [NUM_VC-1:0]        fifo_vld, fifo_pop, sel;
  logic [NUM_VC*FLIT_W-1:0] fifo_flit, eb_flit;
  logic [NUM_VC*PORT_W-1:0] vc_port;
  logic [NUM_VC*VC_W-1:0]   vc_ovc;

  assign sel = sa_req_o & sa_gnt_i;

  for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
    vcis_fifo #(.W(FLIT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (in_valid_i && (in_vc_i == VC_W'(v))),
      .data_i  (in_flit_i),
      .pop_i   (fifo_pop[v]),
      .valid_o (fifo_vld[v]),
      .data_o  (fifo_flit[v*FLIT_W +: FLIT_W])
    );

    vcis_vc_ctrl #(
      .NUM_VC(NUM_VC), .NUM_PORT(NUM_PORT), .DEST_W(DEST_W), .DATA_W(DATA_W)
    ) u_ctrl (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .fifo_valid_i (fifo_vld[v]),
      .fifo_flit_i  (fifo_flit[v*FLIT_W +: FLIT_W]),
      .fifo_pop_o   (fifo_pop[v]),
      .va_req_o     (va_req_o[v]),
      .va_port_o    (va_port_o[v*PORT_W +: PORT_W]),
      .va_gnt_i     (va_gnt_i[v]),
      .va_gnt_vc_i  (va_gnt_vc_i[v*VC_W +: VC_W]),
      .cred_ok_i    (cred_ok_i),
      .sa_req_o     (sa_req_o[v]),
      .sa_gnt_i     (sa_gnt_i[v]),
      .eb_flit_o    (eb_flit[v*FLIT_W +: FLIT_W]),
      .out_port_o   (vc_port[v*PORT_W +: PORT_W]),
      .out_vc_o     (vc_ovc[v*VC_W +: VC_W])
    );
  end

  vcis_out_reg #(
    .NUM_VC(NUM_VC), .FLIT_W(FLIT_W), .PORT_W(PORT_W), .VC_W(VC_W)
  ) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (sel),
    .flits_i (eb_flit),
    .ports_i (vc_port),
    .vcs_i   (vc_ovc),
    .valid_o (out_valid_o),
    .flit_o  (out_flit_o),
    .port_o  (out_port_o),
    .vc_o    (out_vc_o)
  );
endmodule

// File: rtl/vcis_checker.sv
module vcis_checker #(
  parameter int NUM_VC   = 2,
  parameter int NUM_PORT = 4,
  localparam int PORT_W  = $clog2(NUM_PORT)
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [NUM_VC-1:0]        va_req_i,
  input logic [NUM_VC-1:0]        va_gnt_i,
  input logic [NUM_VC*PORT_W-1:0] va_port_i,
  input logic [NUM_VC-1:0]        sa_req_i,
  input logic [NUM_VC-1:0]        sa_gnt_i,
  input logic                     out_valid_i
);
  for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
    a_r4_va_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (va_req_i[v] && !va_gnt_i[v]) |=> va_req_i[v]);
    a_r4_port_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (va_req_i[v] && !va_gnt_i[v]) |=> $stable(va_port_i[v*PORT_W +: PORT_W]));
    a_r6_no_sa_before_va: assert property (@(posedge clk_i) disable iff (!rst_ni)
      va_req_i[v] |-> !sa_req_i[v]);
  end

  a_r10_single_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sa_gnt_i & sa_req_i));
  a_r10_out_from_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_i |-> $past(|(sa_gnt_i & sa_req_i)));
  a_r10_grant_to_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(sa_gnt_i & sa_req_i)) |=> out_valid_i);
endmodule

bind vc_input_stage vcis_checker #(.NUM_VC(NUM_VC), .NUM_PORT(NUM_PORT)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .va_req_i    (va_req_o),
  .va_gnt_i    (va_gnt_i),
  .va_port_i   (va_port_o),
  .sa_req_i    (sa_req_o),
  .sa_gnt_i    (sa_gnt_i),
  .out_valid_i (out_valid_o)
);

// File: tb/sim_vc_input_stage.sv
module sim_vc_input_stage;
  localparam int NUM_VC = 2, NUM_PORT = 4, DEST_W = 4, DATA_W = 16;
  localparam int FLIT_W = 2 + DEST_W + DATA_W;
  localparam int PORT_W = $clog2(NUM_PORT);
  localparam int VC_W   = $clog2(NUM_VC);

  typedef struct packed {
    logic [VC_W-1:0]   vc;
    logic [PORT_W-1:0] port;
    logic [FLIT_W-1:0] flit;
  } exp_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic in_valid = 1'b0;
  logic [VC_W-1:0] in_vc = '0;
  logic [FLIT_W-1:0] in_flit = '0;
  logic [NUM_VC-1:0] va_req, va_gnt, sa_req, sa_gnt;
  logic [NUM_VC*PORT_W-1:0] va_port;
  logic [NUM_VC*VC_W-1:0] va_gnt_vc;
  logic [NUM_PORT*NUM_VC-1:0] cred = '1;
  logic out_valid;
  logic [FLIT_W-1:0] out_flit;
  logic [PORT_W-1:0] out_port;
  logic [VC_W-1:0] out_vc;
  logic va_en = 1'b1, sa_en = 1'b1;

  int cyc = 0, nchk = 0, nfail = 0;
  bit done = 1'b0;
  exp_t exp_q[$];
  int obs_cyc[$];
  logic [PORT_W-1:0] head_port [NUM_VC];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  vc_input_stage u0 (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .in_vc_i(in_vc),
    .in_flit_i(in_flit), .va_req_o(va_req), .va_port_o(va_port),
    .va_gnt_i(va_gnt), .va_gnt_vc_i(va_gnt_vc), .cred_ok_i(cred),
    .sa_req_o(sa_req), .sa_gnt_i(sa_gnt), .out_valid_o(out_valid),
    .out_flit_o(out_flit), .out_port_o(out_port), .out_vc_o(out_vc)
  );

  // allocator models: VC v receives output VC NUM_VC-1-v; switch is fixed priority, low index first
  always_comb begin
    va_gnt = va_req & {NUM_VC{va_en}};
    for (int v = 0; v < NUM_VC; v++) va_gnt_vc[v*VC_W +: VC_W] = VC_W'(NUM_VC - 1 - v);
    sa_gnt = '0;
    for (int v = NUM_VC - 1; v >= 0; v--)
      if (sa_en && sa_req[v]) sa_gnt = NUM_VC'(1) << v;
  end

  task automatic chk(input bit ok, input string r, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", r, what, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    int idx, stream;
    if (rst_ni && out_valid) begin
      stream = NUM_VC - 1 - int'(out_vc);
      idx = -1;
      for (int i = 0; i < exp_q.size(); i++)
        if (idx < 0 && int'(exp_q[i].vc) == stream) idx = i;
      obs_cyc.push_back(cyc);
      if (idx < 0) begin
        chk(1'b0, "R9", "unexpected flit on out vc", int'(out_vc), -1);
      end else begin
        chk(out_flit == exp_q[idx].flit, "R9", "flit bits", int'(out_flit), int'(exp_q[idx].flit));
        chk(out_port == exp_q[idx].port, "R2", "output port", int'(out_port), int'(exp_q[idx].port));
        exp_q.delete(idx);
      end
    end
  end

  task automatic push(input int vc, input bit h, input bit t, input int dest, input int pl, output int pc);
    logic [FLIT_W-1:0] f;
    @(negedge clk);
    f = {h, t, DEST_W'(dest), DATA_W'(pl)};
    in_valid = 1'b1;
    in_vc = VC_W'(vc);
    in_flit = f;
    if (h) head_port[vc] = PORT_W'(dest);
    exp_q.push_back({VC_W'(vc), head_port[vc], f});
    pc = cyc + 1;
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int p, d;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
    chk(va_req == '0, "R1", "va_req in reset", int'(va_req), 0);
    chk(sa_req == '0, "R1", "sa_req in reset", int'(sa_req), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0 && sa_req == '0, "R1", "idle after reset", int'(out_valid), 0);

    // R3 R5: head latency and back-to-back body/tail; body dest differs (R9)
    obs_cyc.delete();
    push(0, 1, 0, 5, 16'h1111, p);
    push(0, 0, 0, 12, 16'h2222, d);
    push(0, 0, 1, 7, 16'h3333, d);
    idle(10);
    chk(obs_cyc.size() == 3, "R5", "flit count", obs_cyc.size(), 3);
    if (obs_cyc.size() == 3) begin
      chk(obs_cyc[0] == p + 3, "R3", "head out cycle", obs_cyc[0], p + 3);
      chk(obs_cyc[1] == p + 4, "R5", "body out cycle", obs_cyc[1], p + 4);
      chk(obs_cyc[2] == p + 5, "R5", "tail out cycle", obs_cyc[2], p + 5);
    end

    // R7: next packet on same VC reallocates, one idle cycle
    obs_cyc.delete();
    push(1, 1, 0, 5, 16'hA001, p);
    push(1, 0, 1, 9, 16'hA002, d);
    push(1, 1, 1, 2, 16'hA003, d);
    idle(12);
    chk(obs_cyc.size() == 3, "R7", "flit count", obs_cyc.size(), 3);
    if (obs_cyc.size() == 3) begin
      chk(obs_cyc[1] == p + 4, "R7", "tail out cycle", obs_cyc[1], p + 4);
      chk(obs_cyc[2] == p + 6, "R7", "next head out cycle", obs_cyc[2], p + 6);
    end

    // R8: interleaved VCs
    obs_cyc.delete();
    push(0, 1, 0, 1, 16'hB001, p);
    push(0, 0, 0, 1, 16'hB002, d);
    push(1, 1, 0, 14, 16'hC001, d);
    push(0, 0, 0, 1, 16'hB003, d);
    push(0, 0, 1, 1, 16'hB004, d);
    push(1, 0, 1, 14, 16'hC002, d);
    idle(14);
    chk(obs_cyc.size() == 6, "R8", "flit count", obs_cyc.size(), 6);
    if (obs_cyc.size() == 6) begin
      chk(obs_cyc[0] == p + 3, "R8", "first out cycle", obs_cyc[0], p + 3);
      chk(obs_cyc[5] == p + 8, "R8", "last out cycle", obs_cyc[5], p + 8);
    end

    // R6: credit withheld for port 3 / out vc 1 (index 7)
    obs_cyc.delete();
    cred[3*NUM_VC + 1] = 1'b0;
    push(0, 1, 1, 3, 16'hD001, p);
    idle(6);
    chk(sa_req[0] == 1'b0, "R6", "sa_req without credit", int'(sa_req[0]), 0);
    chk(va_req[0] == 1'b0, "R6", "va_req after lock", int'(va_req[0]), 0);
    chk(obs_cyc.size() == 0, "R6", "no output without credit", obs_cyc.size(), 0);
    d = cyc;
    cred[3*NUM_VC + 1] = 1'b1;
    #1;
    chk(sa_req[0] == 1'b1, "R6", "sa_req with credit", int'(sa_req[0]), 1);
    repeat (4) @(negedge clk);
    chk(obs_cyc.size() == 1 && obs_cyc[0] == d + 1, "R6", "out cycle after credit",
        obs_cyc.size() > 0 ? obs_cyc[0] : -1, d + 1);

    // R4: allocation withheld
    obs_cyc.delete();
    va_en = 1'b0;
    push(1, 1, 1, 6, 16'hE001, p);
    idle(4);
    chk(va_req[1] == 1'b1, "R4", "va_req held", int'(va_req[1]), 1);
    chk(va_port[1*PORT_W +: PORT_W] == 2'd2, "R4", "va_port", int'(va_port[1*PORT_W +: PORT_W]), 2);
    chk(obs_cyc.size() == 0, "R4", "no output before grant", obs_cyc.size(), 0);
    d = cyc;
    va_en = 1'b1;
    repeat (4) @(negedge clk);
    chk(obs_cyc.size() == 1 && obs_cyc[0] == d + 2, "R10", "out cycle after grant",
        obs_cyc.size() > 0 ? obs_cyc[0] : -1, d + 2);

    // R1: reset mid-packet discards contents
    obs_cyc.delete();
    va_en = 1'b0;
    push(0, 1, 0, 1, 16'hF001, d);
    push(0, 0, 1, 1, 16'hF002, d);
    idle(3);
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    exp_q.delete();
    va_en = 1'b1;
    repeat (8) @(negedge clk);
    chk(obs_cyc.size() == 0, "R1", "flits after reset", obs_cyc.size(), 0);
    chk(va_req == '0 && sa_req == '0, "R1", "requests after reset", int'(va_req), 0);

    chk(exp_q.size() == 0, "R9", "scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule